// File: doc/BRIEF.md
# Dual-Load Bank Conflict Arbiter

This block stands between two load pipes and a banked level-one data array. Each cycle it may be offered two 32-bit aligned loads, one per input slot. Each load carries a byte address and a valid bit. The block checks whether the two candidates would fight over the same array bank. If they are compatible, it sends both to the array in that cycle. If not, it sends the older one, parks the younger one in a hold register, and sends the parked load first on the next cycle.

The array is modelled as eight 32-bit banks, each accessed twice per core cycle, so bank selection is effectively sixteen-way on address bits 5:2. Lines are 64 bytes. The set index is bits 11:6, and the line identity is bits 31:6. A 32-bit saturating counter records every cycle in which a ready load is held back by a conflict.

Control is a two-state machine:
- `ST_FLOW`: no load is parked, and both input slots are ready.
- `ST_HELD`: a parked load owns output lane 0, and only slot 0 may join it.

There are two transitions:
- SPLIT (`ST_FLOW` to `ST_HELD`): taken when both slots present conflicting loads.
- DRAIN (`ST_HELD` to `ST_FLOW`): taken on every cycle spent in `ST_HELD`.

Top module: `ldarb_dual_issue`

## Requirements
- R1: Two loads conflict when all three hold: their bits 31:6 differ, their set bits 11:6 are equal, and their bank bits 5:2 are equal. Two conflicting loads are never issued in the same cycle.
- R2: Two loads with equal bits 31:6 (same line) never conflict, even at the same word, and issue together.
- R3: Loads to different lines issue together when their set bits differ or any of bits 5:2 differ. A difference in bit 2 alone is enough.
- R4: On a conflict in ST_FLOW, slot 0 issues on lane 0 and slot 1 is parked. The parked load issues on lane 0 in the next cycle, ahead of any new arrival. A new slot 0 load joins it on lane 1 if the two are compatible.
- R5: In ST_HELD, in1_ready is low. in0_ready is low when the slot 0 load conflicts with the parked load; that slot 0 load then waits.
- R6: Issue keeps program order: slot 0 before slot 1, and parked loads before newer ones. Lane 1 is used only when lane 0 is in use. A lone request, from either slot, goes out on lane 0.
- R7: stall_count increments by one on each cycle in which a ready load is held back by a conflict, and saturates at its all-ones value.
- R8: A synchronous active-high reset clears stall_count and enters ST_FLOW. While rst is high, both readies and both lane valids are low. After reset, both readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| in0_valid | input | 1 | Slot 0 (older) load present |
| in0_addr | input | AW | Slot 0 byte address |
| in0_ready | output | 1 | Slot 0 load accepted this cycle |
| in1_valid | input | 1 | Slot 1 (younger) load present |
| in1_addr | input | AW | Slot 1 byte address |
| in1_ready | output | 1 | Slot 1 load accepted this cycle |
| out0_valid | output | 1 | Lane 0 issues a load to the array |
| out0_addr | output | AW | Lane 0 address |
| out1_valid | output | 1 | Lane 1 issues a load to the array |
| out1_addr | output | AW | Lane 1 address |
| stall_count | output | CNT_W | Saturating count of conflict cycles |

## Verification
The assertions assume two things about the inputs. First, a slot keeps its valid bit and address steady until it sees ready. Second, slot 1 always carries the younger load. They also assume reset is held for at least two cycles, so that history checks never reach values from before reset. The bench driver keeps to these rules: it raises a slot's valid bit at a falling edge, holds the slot until the cycle in which ready was high, and holds reset for several cycles. The stimulus covers three address patterns across lines of one set: same-offset streams, offset-shifted streams, and same-line pairs.

// File: rtl/ldarb_pkg.sv
package ldarb_pkg;
    typedef enum logic {
        ST_FLOW = 1'b0,
        ST_HELD = 1'b1
    } arb_state_e;
endpackage

// File: rtl/ldarb_clash.sv
module ldarb_clash #(
    parameter int AW      = 32,
    parameter int LINE_LG = 6,
    parameter int SET_LG  = 6,
    parameter int WORD_LG = 2
) (
    input  logic [AW-1:0] addr_a,
    input  logic [AW-1:0] addr_b,
    output logic          clash
);
    localparam int SET_HI = LINE_LG + SET_LG - 1;

    logic line_differs, set_matches, bank_matches;
    logic unused_lo;

    assign line_differs = addr_a[AW-1:LINE_LG] != addr_b[AW-1:LINE_LG];
    assign set_matches  = addr_a[SET_HI:LINE_LG] == addr_b[SET_HI:LINE_LG];
    assign bank_matches = addr_a[LINE_LG-1:WORD_LG] == addr_b[LINE_LG-1:WORD_LG];
    assign clash        = line_differs && set_matches && bank_matches;
    assign unused_lo    = ^{addr_a[WORD_LG-1:0], addr_b[WORD_LG-1:0]};
endmodule

// File: rtl/ldarb_stall_ctr.sv
module ldarb_stall_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (bump && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/ldarb_dual_issue.sv
module ldarb_dual_issue
    import ldarb_pkg::*;
#(
    parameter int AW      = 32,
    parameter int LINE_LG = 6,
    parameter int SET_LG  = 6,
    parameter int WORD_LG = 2,
    parameter int CNT_W   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in0_valid,
    input  logic [AW-1:0]    in0_addr,
    output logic             in0_ready,
    input  logic             in1_valid,
    input  logic [AW-1:0]    in1_addr,
    output logic             in1_ready,
    output logic             out0_valid,
    output logic [AW-1:0]    out0_addr,
    output logic             out1_valid,
    output logic [AW-1:0]    out1_addr,
    output logic [CNT_W-1:0] stall_count
);
    arb_state_e    state_q, state_d;
    logic [AW-1:0] held_q, held_d;
    logic          clash_new, clash_held, stall_inc;

    // Fresh pair: slot 0 against slot 1.
    ldarb_clash #(.AW(AW), .LINE_LG(LINE_LG), .SET_LG(SET_LG), .WORD_LG(WORD_LG)) u_clash_new (
        .addr_a (in0_addr),
        .addr_b (in1_addr),
        .clash  (clash_new)
    );

    // Parked load against the new slot 0 arrival.
    ldarb_clash #(.AW(AW), .LINE_LG(LINE_LG), .SET_LG(SET_LG), .WORD_LG(WORD_LG)) u_clash_held (
        .addr_a (held_q),
        .addr_b (in0_addr),
        .clash  (clash_held)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FLOW;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        held_d     = held_q;
        in0_ready  = 1'b0;
        in1_ready  = 1'b0;
        out0_valid = 1'b0;
        out0_addr  = '0;
        out1_valid = 1'b0;
        out1_addr  = '0;
        stall_inc  = 1'b0;
        if (!rst) begin
            unique case (state_q)
                ST_FLOW: begin
                    in0_ready = 1'b1;
                    in1_ready = 1'b1;
                    if (in0_valid) begin
                        out0_valid = 1'b1;
                        out0_addr  = in0_addr;
                        if (in1_valid && clash_new) begin
                            held_d    = in1_addr;   // SPLIT
                            state_d   = ST_HELD;
                            stall_inc = 1'b1;
                        end else if (in1_valid) begin
                            out1_valid = 1'b1;
                            out1_addr  = in1_addr;
                        end
                    end else if (in1_valid) begin
                        out0_valid = 1'b1;
                        out0_addr  = in1_addr;
                    end
                end
                ST_HELD: begin
                    out0_valid = 1'b1;                  // DRAIN
                    out0_addr  = held_q;
                    state_d    = ST_FLOW;
                    if (in0_valid && clash_held) begin
                        stall_inc = 1'b1;
                    end else begin
                        in0_ready = 1'b1;
                        if (in0_valid) begin
                            out1_valid = 1'b1;
                            out1_addr  = in0_addr;
                        end
                    end
                end
                default: state_d = ST_FLOW;
            endcase
        end
    end

    ldarb_stall_ctr #(.CNT_W(CNT_W)) u_stall_ctr (
        .clk   (clk),
        .rst   (rst),
        .bump  (stall_inc),
        .count (stall_count)
    );
endmodule

// File: rtl/ldarb_dual_issue_chk.sv
module ldarb_dual_issue_chk #(
    parameter int AW      = 32,
    parameter int LINE_LG = 6,
    parameter int SET_LG  = 6,
    parameter int WORD_LG = 2,
    parameter int CNT_W   = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in0_valid,
    input logic [AW-1:0]    in0_addr,
    input logic             in0_ready,
    input logic             in1_valid,
    input logic [AW-1:0]    in1_addr,
    input logic             in1_ready,
    input logic             out0_valid,
    input logic [AW-1:0]    out0_addr,
    input logic             out1_valid,
    input logic [AW-1:0]    out1_addr,
    input logic [CNT_W-1:0] stall_count
);
    localparam int SET_HI = LINE_LG + SET_LG - 1;
    localparam logic [CNT_W-1:0] TOP = '1;

    logic lanes_fight;
    assign lanes_fight = (out0_addr[SET_HI:WORD_LG] == out1_addr[SET_HI:WORD_LG])
                      && (out0_addr[AW-1:SET_HI+1] != out1_addr[AW-1:SET_HI+1]);

    // R1
    assert_lanes_no_clash_R1: assert property (@(posedge clk) disable iff (rst)
        (out0_valid && out1_valid) |-> !lanes_fight);

    // R6
    assert_lane1_needs_lane0_R6: assert property (@(posedge clk) disable iff (rst)
        out1_valid |-> out0_valid);

    // R6
    assert_dual_keeps_order_R6: assert property (@(posedge clk) disable iff (rst)
        (in0_valid && in0_ready && in1_valid && in1_ready && out1_valid)
        |-> (out0_addr == in0_addr && out1_addr == in1_addr));

    // R4
    assert_parked_goes_next_R4: assert property (@(posedge clk) disable iff (rst)
        (in0_valid && in0_ready && in1_valid && in1_ready && !out1_valid)
        |=> (out0_valid && out0_addr == $past(in1_addr)));

    // R5
    assert_held_owns_lane0_R5: assert property (@(posedge clk) disable iff (rst)
        !in1_ready |-> out0_valid);

    // R7
    assert_count_steps_R7: assert property (@(posedge clk) disable iff (rst)
        (stall_count != TOP) |=> (stall_count == $past(stall_count)
                                  || stall_count == $past(stall_count) + 1'b1));

    // R7
    assert_count_sticks_R7: assert property (@(posedge clk) disable iff (rst)
        (stall_count == TOP) |=> (stall_count == TOP));
endmodule

bind ldarb_dual_issue ldarb_dual_issue_chk #(
    .AW(AW), .LINE_LG(LINE_LG), .SET_LG(SET_LG), .WORD_LG(WORD_LG), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst),
    .in0_valid(in0_valid), .in0_addr(in0_addr), .in0_ready(in0_ready),
    .in1_valid(in1_valid), .in1_addr(in1_addr), .in1_ready(in1_ready),
    .out0_valid(out0_valid), .out0_addr(out0_addr),
    .out1_valid(out1_valid), .out1_addr(out1_addr),
    .stall_count(stall_count)
);

// File: tb/ldarb_dual_issue_test.sv
module ldarb_dual_issue_test;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in0_valid = 1'b0, in1_valid = 1'b0;
    logic [31:0] in0_addr = '0, in1_addr = '0;
    logic in0_ready, in1_ready, out0_valid, out1_valid;
    logic [31:0] out0_addr, out1_addr;
    logic [CW-1:0] stall_count;

    int n_checks = 0, n_fail = 0;
    int issue_cycles = 0, dual_cycles = 0;
    bit finished = 0;
    logic [31:0] q_exp[$];

    always #10 clk = ~clk;

    ldarb_dual_issue #(.CNT_W(CW)) uut (
        .clk(clk), .rst(rst),
        .in0_valid(in0_valid), .in0_addr(in0_addr), .in0_ready(in0_ready),
        .in1_valid(in1_valid), .in1_addr(in1_addr), .in1_ready(in1_ready),
        .out0_valid(out0_valid), .out0_addr(out0_addr),
        .out1_valid(out1_valid), .out1_addr(out1_addr),
        .stall_count(stall_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic pop_cmp(input logic [31:0] got);
        if (q_exp.size() == 0) check("R6 unexpected issue", got, 32'hffff_ffff);
        else check("R6 issue order", got, q_exp.pop_front());
    endtask

    // Monitor: compare issued loads against the scoreboard queue.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (!rst) begin
                if (out0_valid) begin
                    issue_cycles++;
                    pop_cmp(out0_addr);
                end
                if (out1_valid) begin
                    dual_cycles++;
                    if (!out0_valid) check("R6 lane1 alone", 1, 0);
                    pop_cmp(out1_addr);
                end
            end
        end
    end

    // Driver: called at a falling edge, holds each slot until accepted.
    task automatic send(input logic v0, input logic [31:0] a0,
                        input logic v1, input logic [31:0] a1);
        logic p0, p1, t0, t1;
        if (v0) q_exp.push_back(a0);
        if (v1) q_exp.push_back(a1);
        p0 = v0; p1 = v1;
        in0_valid = v0; in0_addr = a0;
        in1_valid = v1; in1_addr = a1;
        while (p0 || p1) begin
            #1;
            t0 = p0 && in0_ready;
            t1 = p1 && in1_ready;
            @(negedge clk);
            if (t0) begin p0 = 1'b0; in0_valid = 1'b0; end
            if (t1) begin p1 = 1'b0; in1_valid = 1'b0; end
        end
    endtask

    task automatic idle(input int n);
        in0_valid = 1'b0;
        in1_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    int s0, ic0, dc0;
    task automatic mark();
        s0 = int'(stall_count); ic0 = issue_cycles; dc0 = dual_cycles;
    endtask
    task automatic expect_deltas(input string req, input int ds, input int dic, input int ddc);
        check({req, " stall delta"}, int'(stall_count) - s0, ds);
        check({req, " issue cycles"}, issue_cycles - ic0, dic);
        check({req, " dual cycles"}, dual_cycles - dc0, ddc);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #5;
        check("R8 ready0 in reset", in0_ready, 0);
        check("R8 lane0 in reset", out0_valid, 0);
        @(negedge clk);
        rst = 1'b0;
        #5;
        check("R8 ready0 after reset", in0_ready, 1);
        check("R8 ready1 after reset", in1_ready, 1);
        check("R8 counter cleared", stall_count, 0);
        @(negedge clk);

        // R2: identical address and adjacent words in one line.
        mark(); send(1, 32'h0000_2040, 1, 32'h0000_2040); idle(2);
        expect_deltas("R2 same word", 0, 1, 1);
        mark(); send(1, 32'h0000_3000, 1, 32'h0000_3004); idle(2);
        expect_deltas("R2 adjacent words", 0, 1, 1);

        // R3: bit 2 differs only; set differs only.
        mark(); send(1, 32'h0000_1000, 1, 32'h0000_2004); idle(2);
        expect_deltas("R3 bit2 differs", 0, 1, 1);
        mark(); send(1, 32'h0000_1000, 1, 32'h0000_2040); idle(2);
        expect_deltas("R3 set differs", 0, 1, 1);

        // R1/R7: eight loads, same offset, eight lines of set 0 -> 7 stalls.
        mark();
        for (int i = 0; i < 4; i++)
            send(1, (2*i+1)*32'h1000 + 32'h10, 1, (2*i+2)*32'h1000 + 32'h10);
        idle(3);
        expect_deltas("R1 same-offset stream", 7, 8, 0);

        // R3: offset shifted by one word per line -> no stalls.
        mark();
        for (int i = 0; i < 4; i++)
            send(1, (2*i)*32'h1004, 1, (2*i+1)*32'h1004);
        idle(3);
        expect_deltas("R3 shifted stream", 0, 4, 4);

        // R4: parked B joins compatible new C; D follows alone.
        mark();
        send(1, 32'h0000_5000, 1, 32'h0000_6000);
        #1;
        check("R5 ready1 low while held", in1_ready, 0);
        @(negedge clk);
        idle(3);
        expect_deltas("R4 park only", 1, 2, 0);
        mark();
        send(1, 32'h0000_5000, 1, 32'h0000_6000);
        send(1, 32'h0000_5004, 1, 32'h0000_7004);
        idle(3);
        expect_deltas("R4 park then join", 1, 3, 1);

        // R5: new slot 0 conflicts with parked load and must wait.
        mark();
        send(1, 32'h0000_5000, 1, 32'h0000_6000);
        in0_valid = 1'b1; in0_addr = 32'h0000_7000;
        #1;
        check("R5 ready0 low on held clash", in0_ready, 0);
        send(1, 32'h0000_7000, 1, 32'h0000_7004);
        idle(3);
        expect_deltas("R5 held clash", 2, 3, 1);

        // R6: lone slot 1 load goes out on lane 0.
        mark(); send(0, 32'h0, 1, 32'h0000_8000); idle(2);
        expect_deltas("R6 lone slot1", 0, 1, 0);

        // R7: drive conflicts past the 4-bit limit.
        for (int i = 0; i < 5; i++)
            send(1, (i+1)*32'h1000 + 32'h20, 1, (i+20)*32'h1000 + 32'h20);
        idle(3);
        check("R7 saturated", stall_count, 15);
        send(1, 32'h0000_1000, 1, 32'h0000_2000);
        idle(3);
        check("R7 stays saturated", stall_count, 15);
        check("R6 scoreboard drained", q_exp.size(), 0);
        summary();
    end
endmodule